// File: doc/BRIEF.md
# Quad PSRAM Start-Up Sequencer

This block takes an external quad-capable PSRAM from whatever line mode it happens to be in and leaves it ready for four-line traffic. After a one-cycle `start` pulse it sends a fixed series of commands to a serial transaction engine. The engine sits outside this block. The sequencer reads and checks the device identification word, re-reads it once if the check fails, resets the device and finally switches it into quad mode.

Each step is a single request on a request/completion port. The sequencer raises `req_valid` for one cycle with the opcode, the line mode and the phase lengths. It then waits for the engine's `eng_done` before it moves on, so at most one request is ever outstanding. When the run ends, the block reports one of two results, and the result stays up until the next `start`:

- `done`, together with the decoded density code and size in bytes, or
- `error`, if both ID reads fail the check.

Top module: `psram_boot_seq`

## Requirements
- R1: The first request after `start` is opcode 0xF5 with `req_quad`=1 and both phase lengths zero.
- R2: An ID read is opcode 0x9F with `req_quad`=0, `req_addr_bits`=24 and `req_rd_bits`=24. The engine returns the 24-bit word on `eng_rdata` when it completes.
- R3: An ID word is accepted only when bits [15:8] equal 0x5D. An accepted first read goes straight on to the reset steps.
- R4: If the first ID word is rejected, exactly one more ID read is issued. If that one is also rejected, `error` is raised and no further request is made.
- R5: The extended byte is bits [23:16] of the accepted word. `density` shows its bits [7:5]. `size_bytes` is 8388608 when the byte equals 0x26. Otherwise a code of 0 gives 2097152, 1 gives 4194304, 2 gives 8388608 and any other code gives 0.
- R6: After an accepted ID the block issues 0x66, then 0x99, then 0x35. Each of these is a single-line request with no address and no read phase.
- R7: `req_valid` is never raised while a request is pending. Only the `eng_done` for the pending request advances the sequence.
- R8: The 0x35 request is presented exactly RST_GAP+1 clocks after the clock edge at which the completion of 0x99 is seen.
- R9: `done` and `error` are mutually exclusive and stay set until the next `start`. Starting a new run clears them in the cycle after the start pulse.
- R10: `start` has no effect while `busy` is high. The run in progress issues exactly its normal request sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin the sequence |
| req_valid | output | 1 | One-cycle request strobe to the engine |
| req_opcode | output | 8 | Command opcode of the request |
| req_quad | output | 1 | 1: command sent on four lines; 0: single line |
| req_addr_bits | output | 5 | Length of the address phase in bits (address is zero) |
| req_rd_bits | output | 5 | Length of the read-data phase in bits |
| eng_done | input | 1 | Completion pulse from the engine |
| eng_rdata | input | 24 | Read data captured by the engine |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky successful-completion flag |
| error | output | 1 | Sticky ID-failure flag |
| density | output | 3 | Density code from the extended ID byte |
| size_bytes | output | 32 | Decoded memory size in bytes |

## Verification
The bench sweeps all eight density codes, plus the 0x26 byte whose density bits alone would decode to 4 MB. A decoder that misses the override, or that maps codes 3 to 7 to a nonzero size, reports the wrong size. Three ID cases are covered:

- first read rejected and second accepted, where a design without the retry would flag an error;
- both reads rejected, where a design that retried forever or fell through would issue extra requests;
- a single bit off in the 0x5D marker, which must be rejected.

The gap after the reset command is measured in clocks, and `start` is pulsed mid-run to expose a sequence that restarts. Engine latencies of zero and several cycles show whether the sequencer waits for completions.

// File: rtl/psram_boot_seq.sv
module psram_boot_seq #(
  parameter int RST_GAP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        req_valid,
  output logic [7:0]  req_opcode,
  output logic        req_quad,
  output logic [4:0]  req_addr_bits,
  output logic [4:0]  req_rd_bits,
  input  logic        eng_done,
  input  logic [23:0] eng_rdata,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [2:0]  density,
  output logic [31:0] size_bytes
);

  localparam int GW = (RST_GAP < 2) ? 1 : $clog2(RST_GAP);
  localparam logic [7:0] OP_QUIT  = 8'hF5;
  localparam logic [7:0] OP_ID    = 8'h9F;
  localparam logic [7:0] OP_RSTEN = 8'h66;
  localparam logic [7:0] OP_RST   = 8'h99;
  localparam logic [7:0] OP_QUAD  = 8'h35;
  localparam logic [7:0] ID_MARK  = 8'h5D;
  localparam logic [7:0] EID_8M   = 8'h26;
  localparam logic [4:0] ID_BITS  = 5'd24;

  typedef enum logic [3:0] {
    S_IDLE, S_QUIT, S_ID1, S_ID2, S_RSTEN, S_RST, S_GAP, S_QUAD, S_OK, S_BAD
  } st_t;

  st_t st;
  logic pend;
  logic [GW-1:0] gcnt;

  wire cmd_st = (st == S_QUIT) || (st == S_ID1) || (st == S_ID2) ||
                (st == S_RSTEN) || (st == S_RST) || (st == S_QUAD);
  wire id_st  = (st == S_ID1) || (st == S_ID2);
  wire fin    = pend && eng_done;
  wire id_ok  = eng_rdata[15:8] == ID_MARK;
  wire [7:0] eid = eng_rdata[23:16];

  logic [31:0] dec_size;
  always_comb begin
    if (eid == EID_8M) dec_size = 32'd1 << 23;
    else begin
      case (eid[7:5])
        3'd0:    dec_size = 32'd1 << 21;
        3'd1:    dec_size = 32'd1 << 22;
        3'd2:    dec_size = 32'd1 << 23;
        default: dec_size = 32'd0;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_QUIT:  req_opcode = OP_QUIT;
      S_ID1,
      S_ID2:   req_opcode = OP_ID;
      S_RSTEN: req_opcode = OP_RSTEN;
      S_RST:   req_opcode = OP_RST;
      S_QUAD:  req_opcode = OP_QUAD;
      default: req_opcode = 8'h00;
    endcase
  end

  assign req_valid     = cmd_st && !pend;
  assign req_quad      = st == S_QUIT;
  assign req_addr_bits = id_st ? ID_BITS : 5'd0;
  assign req_rd_bits   = id_st ? ID_BITS : 5'd0;
  assign busy          = (st != S_IDLE) && (st != S_OK) && (st != S_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pend       <= 1'b0;
      gcnt       <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
      density    <= 3'd0;
      size_bytes <= 32'd0;
    end else begin
      if (cmd_st && !pend) pend <= 1'b1;
      if (fin) pend <= 1'b0;
      case (st)
        S_IDLE, S_OK, S_BAD: begin
          if (start) begin
            st         <= S_QUIT;
            pend       <= 1'b0;
            done       <= 1'b0;
            error      <= 1'b0;
            density    <= 3'd0;
            size_bytes <= 32'd0;
          end
        end
        S_QUIT:  if (fin) st <= S_ID1;
        S_ID1, S_ID2: begin
          if (fin) begin
            if (id_ok) begin
              st         <= S_RSTEN;
              density    <= eid[7:5];
              size_bytes <= dec_size;
            end else if (st == S_ID1) begin
              st <= S_ID2;
            end else begin
              st    <= S_BAD;
              error <= 1'b1;
            end
          end
        end
        S_RSTEN: if (fin) st <= S_RST;
        S_RST: begin
          if (fin) begin
            st   <= S_GAP;
            gcnt <= '0;
          end
        end
        S_GAP: begin
          if (gcnt == GW'(RST_GAP - 1)) st <= S_QUAD;
          else gcnt <= gcnt + 1'b1;
        end
        S_QUAD: begin
          if (fin) begin
            st   <= S_OK;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_quit_quad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_opcode == OP_QUIT) |-> (req_quad && req_addr_bits == 5'd0 && req_rd_bits == 5'd0));

  p_id_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_opcode == OP_ID) |-> (!req_quad && req_addr_bits == ID_BITS && req_rd_bits == ID_BITS));

  p_single_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_opcode == OP_RSTEN || req_opcode == OP_RST || req_opcode == OP_QUAD))
      |-> (!req_quad && req_rd_bits == 5'd0 && req_addr_bits == 5'd0));

  p_one_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !req_valid);

  p_size_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (size_bytes == 32'd0 || size_bytes == 32'd2097152 ||
              size_bytes == 32'd4194304 || size_bytes == 32'd8388608));

endmodule

// File: tb/psram_boot_seq_tb.sv
module psram_boot_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_valid, req_quad, busy, done, error;
  logic [7:0] req_opcode;
  logic [4:0] req_addr_bits, req_rd_bits;
  logic eng_done = 1'b0;
  logic [23:0] eng_rdata = 24'h0;
  logic [2:0] density;
  logic [31:0] size_bytes;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_boot_seq #(.RST_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_opcode(req_opcode), .req_quad(req_quad),
    .req_addr_bits(req_addr_bits), .req_rd_bits(req_rd_bits),
    .eng_done(eng_done), .eng_rdata(eng_rdata),
    .busy(busy), .done(done), .error(error),
    .density(density), .size_bytes(size_bytes)
  );

  logic [23:0] resp_a = 24'h0, resp_b = 24'h0;
  int lat = 0;

  logic [7:0] log_op [0:255];
  logic       log_q  [0:255];
  logic [4:0] log_ab [0:255];
  logic [4:0] log_rb [0:255];
  int nlog = 0;
  int overlap = 0;
  int cyc = 0, t_rst = 0, t_ent = 0;
  int rid = 0;
  logic eb = 1'b0;
  int ecnt = 0;
  logic [7:0] cur_op = 8'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    eng_done <= 1'b0;
    if (req_valid && (eb || eng_done)) overlap <= overlap + 1;
    if (eng_done && cur_op == 8'h99) t_rst <= cyc;
    if (req_valid && !eb) begin
      eb <= 1'b1;
      ecnt <= lat;
      cur_op <= req_opcode;
      if (nlog < 256) begin
        log_op[nlog] <= req_opcode;
        log_q[nlog]  <= req_quad;
        log_ab[nlog] <= req_addr_bits;
        log_rb[nlog] <= req_rd_bits;
      end
      nlog <= nlog + 1;
      if (req_opcode == 8'hF5) rid <= 0;
      if (req_opcode == 8'h9F) begin
        eng_rdata <= (rid == 0) ? resp_a : resp_b;
        rid <= rid + 1;
      end
      if (req_opcode == 8'h35) t_ent <= cyc;
    end else if (eb) begin
      if (ecnt == 0) begin
        eb <= 1'b0;
        eng_done <= 1'b1;
      end else ecnt <= ecnt - 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic longint exp_size(input logic [7:0] e);
    if (e == 8'h26) return 64'd8388608;
    case (e[7:5])
      3'd0: return 64'd2097152;
      3'd1: return 64'd4194304;
      3'd2: return 64'd8388608;
      default: return 64'd0;
    endcase
  endfunction

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || error) break;
    end
  endtask

  task automatic run(input logic [23:0] a, input logic [23:0] b, input int l, input int poke);
    int base;
    logic ok1, ok2;
    logic [23:0] idw;
    logic [7:0] exp_op [0:5];
    int nexp;
    resp_a = a; resp_b = b; lat = l;
    @(negedge clk);
    base = nlog;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !error, "R9 start clears flags", {busy, done, error}, 3'b100);
    if (poke != 0) begin
      for (int i = 0; i < 3000; i++) begin
        if (nlog - base >= poke) break;
        @(negedge clk);
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_end();
    ok1 = a[15:8] == 8'h5D;
    ok2 = b[15:8] == 8'h5D;
    exp_op[0] = 8'hF5; exp_op[1] = 8'h9F;
    if (ok1) begin
      idw = a; nexp = 5;
      exp_op[2] = 8'h66; exp_op[3] = 8'h99; exp_op[4] = 8'h35; exp_op[5] = 8'h00;
    end else if (ok2) begin
      idw = b; nexp = 6;
      exp_op[2] = 8'h9F; exp_op[3] = 8'h66; exp_op[4] = 8'h99; exp_op[5] = 8'h35;
    end else begin
      idw = 24'h0; nexp = 3;
      exp_op[2] = 8'h9F; exp_op[3] = 8'h00; exp_op[4] = 8'h00; exp_op[5] = 8'h00;
    end
    repeat (6) @(negedge clk);
    chk(nlog - base == nexp, poke != 0 ? "R10 request count" : "R4 request count", nlog - base, nexp);
    for (int k = 0; k < 6; k++) begin
      if (k < nexp && k < nlog - base) begin
        chk(log_op[base+k] == exp_op[k], "R6 opcode order", log_op[base+k], exp_op[k]);
        if (k == 0) begin
          chk(log_q[base] == 1'b1, "R1 quit in quad", log_q[base], 1);
          chk(log_ab[base] == 0 && log_rb[base] == 0, "R1 no phases", {log_ab[base], log_rb[base]}, 0);
        end else if (exp_op[k] == 8'h9F) begin
          chk(!log_q[base+k] && log_ab[base+k] == 24 && log_rb[base+k] == 24, "R2 id shape",
              {log_q[base+k], log_ab[base+k], log_rb[base+k]}, {1'b0, 5'd24, 5'd24});
        end else begin
          chk(!log_q[base+k] && log_ab[base+k] == 0 && log_rb[base+k] == 0, "R6 command only",
              {log_q[base+k], log_ab[base+k], log_rb[base+k]}, 0);
        end
      end
    end
    if (ok1 || ok2) begin
      chk(done && !error, "R3 done", {done, error}, 2'b10);
      chk(density == idw[23:21], "R5 density", density, idw[23:21]);
      chk(size_bytes == exp_size(idw[23:16]), "R5 size", size_bytes, exp_size(idw[23:16]));
      chk(t_ent - t_rst == GAP + 1, "R8 reset gap", t_ent - t_rst, GAP + 1);
    end else begin
      chk(error && !done, "R4 error", {done, error}, 2'b01);
    end
    chk(overlap == 0, "R7 overlap", overlap, 0);
    repeat (5) @(negedge clk);
    chk(done == (ok1 || ok2) && error == !(ok1 || ok2), "R9 sticky", {done, error}, {ok1 || ok2, !(ok1 || ok2)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid && !busy && !done && !error && size_bytes == 0, "R9 reset state",
        {req_valid, busy, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !busy, "R10 idle after reset", {req_valid, busy}, 0);
    for (int d = 0; d < 8; d++) begin
      run({3'(d), 5'b00011, 8'h5D, 8'h00}, 24'h0, (d % 2) * 3, 0);
    end
    run({8'h26, 8'h5D, 8'h11}, 24'h0, 1, 0);
    run({8'h40, 8'h5C, 8'h00}, {8'h26, 8'h5D, 8'h00}, 2, 0);
    run({8'h20, 8'hDD, 8'h00}, {8'h40, 8'h5D, 8'h00}, 0, 0);
    run({8'h00, 8'h00, 8'h00}, {8'h00, 8'h1D, 8'h00}, 1, 0);
    repeat (10) @(negedge clk);
    chk(error && !req_valid, "R4 no request after error", {error, req_valid}, 2'b10);
    run({8'h20, 8'h5D, 8'h00}, 24'h0, 2, 2);
    run({8'h40, 8'h5D, 8'h00}, 24'h0, 0, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule